// File: doc/BRIEF.md
# Reference Clock Start-Up Sequencer

This block is the control state machine of a crystal-referenced clock generator. It runs entirely on the reference clock. Once power-on reset has released and both the active-low reset pin and the output-enable pin are high, it walks through three timed phases: a stabilisation delay, a VCO calibration window and a PLL lock wait. Only then does it enable the output buffers and take them out of high impedance. Each phase lasts a fixed number of reference cycles, and each count is a parameter.

The block also carries the pin-strapped output format to the buffers. The two format pins are sampled at the moment the sequence reaches the active phase. They choose the buffer signalling standard, and one code also switches on a secondary output at the reference rate. Pulling either control pin low, or pulling power-on reset low, aborts the sequence. When the pins return high, the sequence runs again from the start. The pins are not assumed to be synchronous: each one passes through two flip-flops before it is used.

Top module: `refclk_startup_seq`

## Requirements
- R1: While `por_done` is low, every register is cleared on the next clock edge. The outputs then show the reset phase (`phase_oh` = 5'b00001), `out_hiz`=1, `out_drv_en`=0, `calibrating`=0, `locked`=0, `aux_en`=0 and `fmt_code`=2'b00.
- R2: The block stays in the reset phase, with outputs tri-stated, while either `rst_pin_n` or `oe_pin` is low. Both pins pass through a two-flop synchroniser. When both are high before clock edge 1, the delay phase appears after edge 3.
- R3: The delay phase lasts exactly `DLY_CYC` reference cycles.
- R4: The calibration phase lasts exactly `CAL_CYC` cycles, and `calibrating` is 1 for exactly those cycles.
- R5: The lock-wait phase lasts exactly `LCK_CYC` cycles. After it, the active phase is entered and held with `out_drv_en`=1, `out_hiz`=0 and `locked`=1.
- R6: If `rst_pin_n` or `oe_pin` goes low in any phase, the reset phase is showing, with outputs in high impedance, after the third clock edge. When both pins are high again, the full sequence runs from the delay phase.
- R7: `fmt_code` takes the value of `fmt_pin` on entry to the active phase. The codes are 2'b00 CMOS, 2'b01 LVDS, 2'b10 LVPECL and 2'b11 LVPECL with the secondary output. `fmt_code` keeps its value outside the active phase.
- R8: `aux_en` is 1 only in the active phase, and only when the latched code is 2'b11.
- R9: Changing `fmt_pin` during the active phase has no effect on `fmt_code` or `aux_en` until the sequence is run again.
- R10: `phase_oh` is one-hot at all times. Bit 0 is reset, bit 1 is delay, bit 2 is calibrate, bit 3 is lock wait and bit 4 is active. Phases advance only in that order, or return to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_done | input | 1 | Power-on reset released; low is a synchronous reset |
| rst_pin_n | input | 1 | Active-low device reset pin (asynchronous) |
| oe_pin | input | 1 | Output enable pin (asynchronous) |
| fmt_pin | input | 2 | Output format strap pins (asynchronous) |
| phase_oh | output | 5 | One-hot current phase |
| out_drv_en | output | 1 | Output buffer drive enable |
| out_hiz | output | 1 | Output buffer tri-state control |
| fmt_code | output | 2 | Latched buffer format code |
| aux_en | output | 1 | Secondary reference-rate output enable |
| calibrating | output | 1 | VCO calibration in progress |
| locked | output | 1 | Sequence complete, outputs live |

## Verification
The phase is a register, and `phase_oh` mirrors it one-for-one. A wrong state or a stray transition therefore shows on the one-hot output at the very next sampling point. A phase counter that is one cycle off moves a phase boundary by one cycle. The checks sample both sides of every boundary, so this is caught at the first boundary that moves. A format latch taken at the wrong moment shows on `fmt_code` and `aux_en` in the first active cycle, or after a pin change while locked. A lost abort path leaves `out_hiz` low three cycles after a pin drop.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  // Phase encodings; the order is the order of the start-up sequence.
  typedef enum logic [2:0] {
    PH_RST = 3'd0,
    PH_DLY = 3'd1,
    PH_CAL = 3'd2,
    PH_LCK = 3'd3,
    PH_ACT = 3'd4
  } phase_e;

  localparam int NUM_PHASES = 5;

  // Buffer format strap codes.
  typedef enum logic [1:0] {
    FMT_CMOS     = 2'b00,
    FMT_LVDS     = 2'b01,
    FMT_PECL     = 2'b10,
    FMT_PECL_AUX = 2'b11
  } fmt_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import clkseq_pkg::*;
#(
  parameter int DLY_CYC = 16384,
  parameter int CAL_CYC = 550,
  parameter int LCK_CYC = 313,
  parameter int CW      = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          done,
  output phase_e        st,
  output phase_e        nxt,
  output logic          load,
  output logic [CW-1:0] load_val
);
  always_comb begin
    nxt      = st;
    load     = 1'b0;
    load_val = '0;
    if (!run) begin
      nxt = PH_RST;
    end else begin
      case (st)
        PH_RST: begin
          nxt      = PH_DLY;
          load     = 1'b1;
          load_val = CW'(DLY_CYC - 1);
        end
        PH_DLY: if (done) begin
          nxt      = PH_CAL;
          load     = 1'b1;
          load_val = CW'(CAL_CYC - 1);
        end
        PH_CAL: if (done) begin
          nxt      = PH_LCK;
          load     = 1'b1;
          load_val = CW'(LCK_CYC - 1);
        end
        PH_LCK: if (done) nxt = PH_ACT;
        PH_ACT: nxt = PH_ACT;
        default: nxt = PH_RST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= PH_RST;
    else     st <= nxt;
  end

  // R10: phases only step forward by one or fall back to reset
  p_seq_order_r10: assert property (@(posedge clk) disable iff (rst)
    (st != $past(st)) |-> (st == PH_RST || 3'(st) == 3'($past(st)) + 3'd1));

  // R6: a dropped control pin forces the reset phase on the next edge
  p_drop_to_rst_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (st == PH_RST));

  // R2: with both pins high the sequence leaves reset at once
  p_start_dly_r2: assert property (@(posedge clk) disable iff (rst)
    (st == PH_RST && run) |=> (st == PH_DLY));
endmodule

// File: rtl/out_ctrl.sv
module out_ctrl
  import clkseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  phase_e                st,
  input  phase_e                nxt,
  input  logic [1:0]            s_fmt,
  output logic [NUM_PHASES-1:0] phase_oh,
  output logic                  drv_en,
  output logic                  hiz,
  output logic                  calibrating,
  output logic                  locked,
  output logic                  aux_en,
  output logic [1:0]            fmt_code
);
  logic [NUM_PHASES-1:0] oh_d;
  logic                  entering;
  logic [1:0]            fmt_d;
  logic                  act_d;

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_oh
    assign oh_d[i] = (nxt == phase_e'(i));
  end

  assign act_d    = (nxt == PH_ACT);
  assign entering = act_d && (st != PH_ACT);
  assign fmt_d    = entering ? s_fmt : fmt_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_oh    <= NUM_PHASES'(1);
      drv_en      <= 1'b0;
      hiz         <= 1'b1;
      calibrating <= 1'b0;
      locked      <= 1'b0;
      aux_en      <= 1'b0;
      fmt_code    <= FMT_CMOS;
    end else begin
      phase_oh    <= oh_d;
      drv_en      <= act_d;
      hiz         <= !act_d;
      calibrating <= (nxt == PH_CAL);
      locked      <= act_d;
      aux_en      <= act_d && (fmt_d == FMT_PECL_AUX);
      fmt_code    <= fmt_d;
    end
  end

  // R10: exactly one phase flag set
  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh) == 1);

  // R8: secondary output only when live with the aux code latched
  p_aux_gate_r8: assert property (@(posedge clk) disable iff (rst)
    aux_en |-> (drv_en && fmt_code == FMT_PECL_AUX));

  // R9: latched format frozen while locked
  p_fmt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(fmt_code));

  // R2: outside the active phase the buffers are tri-stated
  p_tristate_r2: assert property (@(posedge clk) disable iff (rst)
    !phase_oh[4] |-> (hiz && !drv_en && !locked));

  // R5: driving implies locked and not tri-stated
  p_live_r5: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> (!hiz && locked && !calibrating));
endmodule

// File: rtl/refclk_startup_seq.sv
module refclk_startup_seq
  import clkseq_pkg::*;
#(
  parameter int DLY_CYC = 16384,
  parameter int CAL_CYC = 550,
  parameter int LCK_CYC = 313
) (
  input  logic       clk,
  input  logic       por_done,
  input  logic       rst_pin_n,
  input  logic       oe_pin,
  input  logic [1:0] fmt_pin,
  output logic [4:0] phase_oh,
  output logic       out_drv_en,
  output logic       out_hiz,
  output logic [1:0] fmt_code,
  output logic       aux_en,
  output logic       calibrating,
  output logic       locked
);
  localparam int MAXC = (DLY_CYC > CAL_CYC) ? ((DLY_CYC > LCK_CYC) ? DLY_CYC : LCK_CYC)
                                            : ((CAL_CYC > LCK_CYC) ? CAL_CYC : LCK_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  logic          rst;
  logic [3:0]    pins_s;
  logic          run;
  logic          done;
  logic          load;
  logic [CW-1:0] load_val;
  phase_e        st;
  phase_e        nxt;

  assign rst = !por_done;

  pin_sync #(.W(4), .INIT(4'b0000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rst_pin_n, oe_pin, fmt_pin}),
    .q   (pins_s)
  );

  assign run = pins_s[3] & pins_s[2];

  phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  seq_fsm #(
    .DLY_CYC (DLY_CYC),
    .CAL_CYC (CAL_CYC),
    .LCK_CYC (LCK_CYC),
    .CW      (CW)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .done     (done),
    .st       (st),
    .nxt      (nxt),
    .load     (load),
    .load_val (load_val)
  );

  out_ctrl u_out (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .nxt         (nxt),
    .s_fmt       (pins_s[1:0]),
    .phase_oh    (phase_oh),
    .drv_en      (out_drv_en),
    .hiz         (out_hiz),
    .calibrating (calibrating),
    .locked      (locked),
    .aux_en      (aux_en),
    .fmt_code    (fmt_code)
  );
endmodule

// File: tb/sim_refclk_startup_seq.sv
`timescale 1ns/1ps
module sim_refclk_startup_seq;
  localparam int D = 40;
  localparam int C = 12;
  localparam int L = 9;
  localparam int E = 3 + D + C + L;

  logic       clk = 1'b0;
  logic       por_done;
  logic       rst_pin_n;
  logic       oe_pin;
  logic [1:0] fmt_pin;
  logic [4:0] phase_oh;
  logic       out_drv_en, out_hiz, aux_en, calibrating, locked;
  logic [1:0] fmt_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] lf;

  always #2 clk = ~clk;

  refclk_startup_seq #(.DLY_CYC(D), .CAL_CYC(C), .LCK_CYC(L)) u0 (
    .clk(clk), .por_done(por_done), .rst_pin_n(rst_pin_n), .oe_pin(oe_pin),
    .fmt_pin(fmt_pin), .phase_oh(phase_oh), .out_drv_en(out_drv_en),
    .out_hiz(out_hiz), .fmt_code(fmt_code), .aux_en(aux_en),
    .calibrating(calibrating), .locked(locked)
  );

  function automatic logic [11:0] expv(int ph, logic [1:0] f);
    logic [11:0] v;
    v[11:7] = 5'(1 << ph);
    v[6]    = (ph == 4);
    v[5]    = (ph != 4);
    v[4]    = (ph == 2);
    v[3]    = (ph == 4);
    v[2]    = (ph == 4) && (f == 2'b11);
    v[1:0]  = f;
    return v;
  endfunction

  function automatic int ph_at(int k);
    if (k < 3)         return 0;
    if (k < 3 + D)     return 1;
    if (k < 3 + D + C) return 2;
    if (k < E)         return 3;
    return 4;
  endfunction

  task automatic chk(input string req, input logic [11:0] e);
    logic [11:0] o;
    o = {phase_oh, out_drv_en, out_hiz, calibrating, locked, aux_en, fmt_code};
    n_chk++;
    if (o !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, o, e);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // starts from the reset phase, at a falling edge
  task automatic run_full(input logic [1:0] f);
    rst_pin_n = 1'b1; oe_pin = 1'b1; fmt_pin = f;
    step(2);     chk("R2 sync latency", expv(0, lf));
    step(1);     chk("R3 delay entry R10", expv(1, lf));
    step(D - 1); chk("R3 delay last cycle", expv(1, lf));
    step(1);     chk("R4 calibrate entry", expv(2, lf));
    step(C - 1); chk("R4 calibrate last cycle", expv(2, lf));
    step(1);     chk("R5 lock-wait entry", expv(3, lf));
    step(L - 1); chk("R5 lock-wait last cycle", expv(3, lf));
    step(1);     lf = f; chk("R5 R7 active with latched format", expv(4, lf));
    step(3);     chk("R5 active held", expv(4, lf));
  endtask

  task automatic drop(input bit use_oe);
    if (use_oe) oe_pin = 1'b0; else rst_pin_n = 1'b0;
    step(3);
    chk("R6 abort to reset", expv(0, lf));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    por_done = 1'b0; rst_pin_n = 1'b1; oe_pin = 1'b1; fmt_pin = 2'b11;
    lf = 2'b00;
    @(negedge clk);
    step(4);
    chk("R1 power-on reset state", expv(0, 2'b00));

    // reset pin low holds the sequence
    por_done = 1'b1; rst_pin_n = 1'b0;
    step(50);
    chk("R2 reset pin held low", expv(0, lf));

    run_full(2'b00);

    // R9: format change while locked is ignored
    fmt_pin = 2'b11;
    step(6);
    chk("R9 format change while locked", expv(4, lf));

    drop(1'b0);
    run_full(2'b11);
    chk("R8 secondary output with code 11", expv(4, 2'b11));

    // output enable low alone holds reset
    drop(1'b1);
    rst_pin_n = 1'b1;
    step(30);
    chk("R6 output enable held low", expv(0, lf));
    run_full(2'b01);

    // power-on reset during active phase
    por_done = 1'b0;
    step(1);
    lf = 2'b00;
    chk("R1 reset during active", expv(0, 2'b00));
    por_done = 1'b1;
    run_full(2'b10);

    // random aborts at random points, then random full runs
    for (int it = 0; it < 24; it++) begin
      logic [1:0] f;
      int k;
      bit which;
      drop($urandom % 2);
      f = 2'($urandom % 4);
      k = 1 + int'($urandom % (E + 5));
      which = 1'($urandom % 2);
      rst_pin_n = 1'b1; oe_pin = 1'b1; fmt_pin = f;
      step(k);
      if (k >= E) lf = f;
      chk("R3 R4 R5 phase at random cycle", expv(ph_at(k), lf));
      if (k + 2 >= E) lf = f;
      drop(which);
      if (it % 3 == 0) begin
        run_full(2'($urandom % 4));
        fmt_pin = ~fmt_pin;
        step(4);
        chk("R9 R8 random format flip while locked", expv(4, lf));
      end
    end

    summary();
    $finish;
  end
endmodule